// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a 32-bit virtual byte address into a 24-bit physical byte address for 1 KB pages. It holds 64 translation entries. The lookup page number is compared against all 64 entries at once, with one comparator per entry. The hit flag, the matching entry index and the physical address appear combinationally in the same cycle. The low 10 address bits pass straight through. A write access that hits marks its entry as modified.

Software loads new translations through a refill port. It supplies only the page number and the frame. The block picks the slot: the lowest-numbered empty slot if there is one, and otherwise the least recently used entry. If the chosen slot holds a valid, modified translation, the block shows that entry's page number and frame with a write-back strobe during the refill cycle, so that the page-table copy can be updated before the slot is overwritten. A flush empties the whole buffer when a new process starts. An invalidate-by-page input removes the translations of one page that has left RAM.

Top module: `xlat_tlb`

## Requirements
- R1: On a hit, `paddr[23:10]` equals the frame of the winning entry and `paddr[9:0]` equals `lookupVaddr[9:0]`. On a miss, `paddr` is `{14'b0, lookupVaddr[9:0]}`.
- R2: `hit` is 1 only when `lookupValid` is 1 and some valid entry's page number equals `lookupVaddr[31:10]`. `hitIndex` is the lowest such index, or 0 on a miss. Both are combinational in the lookup cycle.
- R3: A refill stores the page number and the frame in the chosen slot, marks the slot valid and clears its modified flag, all from the next cycle on.
- R4: A lookup that hits with `lookupWrite` = 1 sets the modified flag of the winning entry.
- R5: A flush makes every entry invalid from the next cycle on.
- R6: The refill slot is the lowest-indexed invalid entry when one exists. Otherwise it is the least recently used entry.
- R7: Recency is updated by every refill (for the filled slot) and by every lookup hit that changes state (for the winning entry). After reset the recency order is entry 0 most recent through entry 63 least recent.
- R8: In a refill cycle whose chosen slot is valid and modified, `wbValid` is 1 and `wbVpn`/`wbFrame` show that slot's old contents. In every other cycle `wbValid` is 0.
- R9: An invalidate-by-page clears the valid bit of every entry whose page number equals `invVpn`.
- R10: When several operations arrive in one cycle, only the highest-priority one changes state. The order is flush, then invalidate, then refill, then lookup. The lookup outputs are still produced combinationally.
- R11: After reset every entry is invalid, so `hit` and `wbValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupVaddr | input | 32 | Virtual byte address to translate |
| lookupWrite | input | 1 | Lookup is a write access |
| hit | output | 1 | Translation found |
| hitIndex | output | 6 | Index of the winning entry |
| paddr | output | 24 | Physical byte address |
| refillValid | input | 1 | Load a new translation |
| refillVpn | input | 22 | Page number to load |
| refillFrame | input | 14 | Frame number to load |
| wbValid | output | 1 | Evicted entry was modified |
| wbVpn | output | 22 | Page number of the evicted entry |
| wbFrame | output | 14 | Frame of the evicted entry |
| flush | input | 1 | Invalidate all entries |
| invValid | input | 1 | Invalidate entries of one page |
| invVpn | input | 22 | Page number to invalidate |

## Verification
The assertions assume the inputs hold steady between clock edges and that no input is unknown once reset is released. They also assume that refill, flush and invalidate follow the stated priority, so that a refill checked for a later hit was not overridden by a flush or an invalidate in the same cycle. The stimulus changes inputs only on the falling edge. It draws page numbers from a small range of 80 values, so that hits, duplicates, evictions of modified entries and collisions between operations all occur, while still letting the 64 entries fill up and roll over.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int VaW     = 32;
  parameter int PaW     = 24;
  parameter int OffW    = 10;
  parameter int Entries = 64;
  localparam int VpnW = VaW - OffW;
  localparam int PfnW = PaW - OffW;
  localparam int IdxW = $clog2(Entries);

  typedef struct packed {
    logic            valid;
    logic            dirty;
    logic [VpnW-1:0] vpn;
    logic [PfnW-1:0] pfn;
  } entry_t;

  typedef struct packed {
    logic            flushAll;
    logic            invPage;
    logic            refill;
    logic            markDirty;
    logic [IdxW-1:0] refillIdx;
    logic [IdxW-1:0] dirtyIdx;
  } strobe_t;
endpackage

// File: rtl/xlat_array.sv
module xlat_array
  import xlat_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [VpnW-1:0]     lookupVpn,
  input  logic [VpnW-1:0]     invVpn,
  input  logic [VpnW-1:0]     refillVpn,
  input  logic [PfnW-1:0]     refillPfn,
  output logic [Entries-1:0]  validVec,
  output logic                hitAny,
  output logic [IdxW-1:0]     hitIdx,
  output logic [PfnW-1:0]     hitPfn,
  output logic                wbValid,
  output logic [VpnW-1:0]     wbVpn,
  output logic [PfnW-1:0]     wbPfn
);
  entry_t mem [Entries];
  logic [Entries-1:0] matchVec;

  genvar g;
  generate
    for (g = 0; g < Entries; g++) begin : gCmp
      assign matchVec[g] = mem[g].valid && (mem[g].vpn == lookupVpn);
      assign validVec[g] = mem[g].valid;
    end
  endgenerate

  // lowest matching index wins
  always_comb begin
    hitAny = 1'b0;
    hitIdx = '0;
    hitPfn = '0;
    for (int i = Entries - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hitAny = 1'b1;
        hitIdx = IdxW'(i);
        hitPfn = mem[i].pfn;
      end
    end
  end

  entry_t victim;
  assign victim  = mem[strobe.refillIdx];
  assign wbValid = strobe.refill && victim.valid && victim.dirty;
  assign wbVpn   = victim.vpn;
  assign wbPfn   = victim.pfn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < Entries; i++) mem[i] <= '0;
    end else if (strobe.flushAll) begin
      for (int i = 0; i < Entries; i++) mem[i].valid <= 1'b0;
    end else if (strobe.invPage) begin
      for (int i = 0; i < Entries; i++)
        if (mem[i].vpn == invVpn) mem[i].valid <= 1'b0;
    end else if (strobe.refill) begin
      mem[strobe.refillIdx] <= '{valid: 1'b1, dirty: 1'b0, vpn: refillVpn, pfn: refillPfn};
    end else if (strobe.markDirty) begin
      mem[strobe.dirtyIdx].dirty <= 1'b1;
    end
  end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru
  import xlat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               invValid,
  input  logic               refillValid,
  input  logic               lookupValid,
  input  logic               lookupWrite,
  input  logic               hitAny,
  input  logic [IdxW-1:0]    hitIdx,
  input  logic [Entries-1:0] validVec,
  output strobe_t            strobe
);
  // age 0 = most recent, Entries-1 = least recent; ages stay a permutation
  logic [IdxW-1:0] age [Entries];
  logic [IdxW-1:0] victimIdx;
  logic            foundFree;
  logic            doRefill, doHit, touch;
  logic [IdxW-1:0] touchIdx;

  always_comb begin
    foundFree = 1'b0;
    victimIdx = '0;
    for (int i = 0; i < Entries; i++) begin
      if (!validVec[i] && !foundFree) begin
        foundFree = 1'b1;
        victimIdx = IdxW'(i);
      end
    end
    if (!foundFree) begin
      for (int i = 0; i < Entries; i++)
        if (age[i] == IdxW'(Entries - 1)) victimIdx = IdxW'(i);
    end
  end

  assign doRefill = !flush && !invValid && refillValid;
  assign doHit    = !flush && !invValid && !refillValid && lookupValid && hitAny;
  assign touch    = doRefill || doHit;
  assign touchIdx = doRefill ? victimIdx : hitIdx;

  always_comb begin
    strobe.flushAll  = flush;
    strobe.invPage   = !flush && invValid;
    strobe.refill    = doRefill;
    strobe.markDirty = doHit && lookupWrite;
    strobe.refillIdx = victimIdx;
    strobe.dirtyIdx  = hitIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < Entries; i++) age[i] <= IdxW'(i);
    end else if (touch) begin
      for (int i = 0; i < Entries; i++) begin
        if (IdxW'(i) == touchIdx) age[i] <= '0;
        else if (age[i] < age[touchIdx]) age[i] <= age[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            lookupValid,
  input  logic [VaW-1:0]  lookupVaddr,
  input  logic            lookupWrite,
  output logic            hit,
  output logic [IdxW-1:0] hitIndex,
  output logic [PaW-1:0]  paddr,
  input  logic            refillValid,
  input  logic [VpnW-1:0] refillVpn,
  input  logic [PfnW-1:0] refillFrame,
  output logic            wbValid,
  output logic [VpnW-1:0] wbVpn,
  output logic [PfnW-1:0] wbFrame,
  input  logic            flush,
  input  logic            invValid,
  input  logic [VpnW-1:0] invVpn
);
  strobe_t            strobe;
  logic [Entries-1:0] validVec;
  logic               hitAny;
  logic [IdxW-1:0]    hitIdx;
  logic [PfnW-1:0]    hitPfn;

  xlat_array u_array (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lookupVpn(lookupVaddr[VaW-1:OffW]), .invVpn(invVpn),
    .refillVpn(refillVpn), .refillPfn(refillFrame),
    .validVec(validVec), .hitAny(hitAny), .hitIdx(hitIdx), .hitPfn(hitPfn),
    .wbValid(wbValid), .wbVpn(wbVpn), .wbPfn(wbFrame)
  );

  xlat_lru u_lru (
    .clk(clk), .rstN(rstN), .flush(flush), .invValid(invValid),
    .refillValid(refillValid), .lookupValid(lookupValid),
    .lookupWrite(lookupWrite), .hitAny(hit), .hitIdx(hitIdx),
    .validVec(validVec), .strobe(strobe)
  );

  assign hit      = lookupValid && hitAny;
  assign hitIndex = hit ? hitIdx : '0;
  assign paddr    = {(hit ? hitPfn : {PfnW{1'b0}}), lookupVaddr[OffW-1:0]};
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk
  import xlat_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            lookupValid,
  input logic [VaW-1:0]  lookupVaddr,
  input logic            hit,
  input logic            refillValid,
  input logic [VpnW-1:0] refillVpn,
  input logic            wbValid,
  input logic            flush,
  input logic            invValid,
  input logic [VpnW-1:0] invVpn
);
  AST_WB_NEEDS_REFILL: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (refillValid && !flush && !invValid)); // R8

  AST_REFILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && !flush && !invValid) |=>
      ((lookupValid && lookupVaddr[VaW-1:OffW] == $past(refillVpn)) -> hit)); // R3

  AST_FLUSH_THEN_MISS: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !hit); // R5

  AST_FLUSH_THEN_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !wbValid); // R8

  AST_INV_THEN_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && !flush) |=>
      ((lookupVaddr[VaW-1:OffW] == $past(invVpn)) -> !hit)); // R9
endmodule

bind xlat_tlb xlat_tlb_chk chk_i (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVaddr(lookupVaddr),
  .hit(hit), .refillValid(refillValid), .refillVpn(refillVpn), .wbValid(wbValid),
  .flush(flush), .invValid(invValid), .invVpn(invVpn)
);

// File: tb/xlat_tlb_tb_top.sv
module xlat_tlb_tb_top;
  localparam int ClkPeriod = 10;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0, lookupWrite = 1'b0;
  logic [31:0] lookupVaddr = '0;
  logic        hit;
  logic [5:0]  hitIndex;
  logic [23:0] paddr;
  logic        refillValid = 1'b0;
  logic [21:0] refillVpn = '0;
  logic [13:0] refillFrame = '0;
  logic        wbValid;
  logic [21:0] wbVpn;
  logic [13:0] wbFrame;
  logic        flush = 1'b0, invValid = 1'b0;
  logic [21:0] invVpn = '0;

  always #(ClkPeriod/2) clk = ~clk;

  xlat_tlb dut_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVaddr(lookupVaddr),
    .lookupWrite(lookupWrite), .hit(hit), .hitIndex(hitIndex), .paddr(paddr),
    .refillValid(refillValid), .refillVpn(refillVpn), .refillFrame(refillFrame),
    .wbValid(wbValid), .wbVpn(wbVpn), .wbFrame(wbFrame),
    .flush(flush), .invValid(invValid), .invVpn(invVpn)
  );

  int vectors = 0, miscompares = 0;

  // reference model
  bit        mValid [N];
  bit        mDirty [N];
  bit [21:0] mVpn   [N];
  bit [13:0] mPfn   [N];
  int        mAge   [N];

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin
      mValid[i] = 0; mDirty[i] = 0; mVpn[i] = '0; mPfn[i] = '0; mAge[i] = i;
    end
  endtask

  function automatic int findHit(bit [21:0] vpn);
    for (int i = 0; i < N; i++) if (mValid[i] && mVpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int pickVictim();
    for (int i = 0; i < N; i++) if (!mValid[i]) return i;
    for (int i = 0; i < N; i++) if (mAge[i] == N - 1) return i;
    return 0;
  endfunction

  task automatic touch(int t);
    int a = mAge[t];
    for (int i = 0; i < N; i++) begin
      if (i == t) mAge[i] = 0;
      else if (mAge[i] < a) mAge[i] = mAge[i] + 1;
    end
  endtask

  task automatic fail(string tag, string what, longint act, longint exp);
    miscompares++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  task automatic step(bit lv, bit [31:0] va, bit wr, bit rf, bit [21:0] rv, bit [13:0] rp,
                      bit fl, bit iv, bit [21:0] ivp, string ctx);
    int h, v;
    bit eHit, eWb;
    bit [23:0] ePa;
    lookupValid = lv; lookupVaddr = va; lookupWrite = wr;
    refillValid = rf; refillVpn = rv; refillFrame = rp;
    flush = fl; invValid = iv; invVpn = ivp;
    #1;
    h = lv ? findHit(va[31:10]) : -1;
    eHit = (h >= 0);
    ePa = {(eHit ? mPfn[h] : 14'd0), va[9:0]};
    v = pickVictim();
    eWb = !fl && !iv && rf && mValid[v] && mDirty[v];
    vectors++;
    if (hit !== eHit) fail({"R2 ", ctx}, "hit", hit, eHit);
    if (hitIndex !== (eHit ? 6'(h) : 6'd0)) fail({"R2 ", ctx}, "hitIndex", hitIndex, eHit ? h : 0);
    if (paddr !== ePa) fail({"R1 ", ctx}, "paddr", paddr, ePa);
    if (wbValid !== eWb) fail({"R8 ", ctx}, "wbValid", wbValid, eWb);
    if (eWb && (wbVpn !== mVpn[v] || wbFrame !== mPfn[v]))
      fail({"R8 ", ctx}, "wb vpn/frame", {wbVpn, wbFrame}, {mVpn[v], mPfn[v]});
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) mValid[i] = 0;
    end else if (iv) begin
      for (int i = 0; i < N; i++) if (mVpn[i] == ivp) mValid[i] = 0;
    end else if (rf) begin
      mValid[v] = 1; mDirty[v] = 0; mVpn[v] = rv; mPfn[v] = rp; touch(v);
    end else if (eHit) begin
      if (wr) mDirty[h] = 1;
      touch(h);
    end
    @(negedge clk);
  endtask

  task automatic look(bit [21:0] vpn, bit [9:0] off, bit wr, string ctx);
    step(1, {vpn, off}, wr, 0, 0, 0, 0, 0, 0, ctx);
  endtask

  task automatic fill(bit [21:0] vpn, bit [13:0] pfn, string ctx);
    step(0, 0, 0, 1, vpn, pfn, 0, 0, 0, ctx);
  endtask

  initial begin
    #(ClkPeriod * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: empty after reset, no write-back
    look(22'h0, 10'h3, 0, "R11 reset");
    // R6 R3: fill 64 slots; empty slots are taken lowest first
    for (int i = 0; i < N; i++) fill(22'h100 + 22'(i), 14'h2000 + 14'(i), "R6 fill");
    for (int i = 0; i < N; i++) look(22'h100 + 22'(i), 10'(i * 7), (i % 3) == 0, "R3 R4 R7");
    // R6 R8: full buffer, LRU victims, dirty ones reported
    for (int i = 0; i < 8; i++) fill(22'h300 + 22'(i), 14'h1000 + 14'(i), "R6 R8 lru");
    for (int i = 0; i < 8; i++) look(22'h300 + 22'(i), 10'h3ff, 0, "R3 lru");
    // R9: invalidate a page, then miss
    step(0, 0, 0, 0, 0, 0, 0, 1, 22'h300, "R9 inv");
    look(22'h300, 10'h1, 0, "R9 miss");
    // R2: duplicate page, lowest index wins
    fill(22'h3aa, 14'h0aa, "R2 dup a");
    fill(22'h3aa, 14'h0bb, "R2 dup b");
    look(22'h3aa, 10'h55, 0, "R2 dup");
    // R10: flush with refill and write-hit in same cycle
    step(1, {22'h301, 10'h0}, 1, 1, 22'h3cc, 14'h3cc, 1, 1, 22'h301, "R10 flush prio");
    look(22'h3cc, 10'h0, 0, "R10 R5");
    look(22'h301, 10'h0, 0, "R5 miss");
    // R10: invalidate beats refill
    step(0, 0, 0, 1, 22'h3dd, 14'h1, 0, 1, 22'h0, "R10 inv prio");
    look(22'h3dd, 10'h0, 0, "R10 no refill");
    // R10: refill beats lookup state change (write-hit not applied)
    fill(22'h3ee, 14'h2, "R10 setup");
    step(1, {22'h3ee, 10'h4}, 1, 1, 22'h3ef, 14'h3, 0, 0, 0, "R10 refill prio");
    // random mix
    for (int k = 0; k < 4000; k++) begin
      int op = $urandom_range(99);
      bit [21:0] vp = 22'($urandom_range(79));
      bit [21:0] rv = 22'($urandom_range(79));
      step($urandom_range(3) != 0, {vp, 10'($urandom)}, $urandom_range(1) == 1,
           op < 30, rv, 14'($urandom), op == 99, (op >= 95 && op < 99), rv, "random");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule